// File: doc/BRIEF.md
# Split-Mode Byte Permute Unit

This block is a byte-granular, all-to-all permute engine for a vector datapath whose operands are 256 bits wide on the wire. In full mode it produces a 512-bit result. Each of the 64 result bytes is picked by its own index byte from a 128-byte pool made of two 64-byte tables. Full-width operands arrive in two beats on the same bus: the lower half first and the upper half on a later cycle. The unit keeps the lower beat in a staging register and fires the whole permute in the cycle the upper beat shows up. As a result, a full-width permute finishes one cycle later than a half-width one.

In split mode the same crossbar serves as two independent 256-bit permuters, one on each result half. Each has its own request port and can do any permute within its own two 32-byte tables. Any half-width request occupies the whole crossbar for its cycle. An upper beat that arrives in such a cycle is not started: the staged lower half is kept and the issuer presents the upper beat again later. Results are registered per half and carry a valid flag per half and a tag that marks full-mode results.

Top module: `perm512_split`

## Requirements
- R1: Full mode: result byte j equals pool byte k, where k is bits 6:0 of index byte j. Pool bytes 0..63 are table A (lower beat supplies bytes 0..31, upper beat bytes 32..63) and pool bytes 64..127 are table B, arranged the same way. Bit 7 of every index byte has no effect.
- R2: Split mode: in half h, result byte j of that half equals byte k[4:0] of that half's table A when k[5]=0, or of its table B when k[5]=1, where k is the half's index byte j. Bits 7:6 have no effect.
- R3: The two halves are independent. A request on only one half port sets only that half's valid flag, and its result does not depend on the other port.
- R4: A half-width request raises its half's valid one clock edge after it is presented, with the full-mode tag low.
- R5: A full-width permute raises both valid flags and the full-mode tag one edge after its upper beat is accepted, which is two edges after its lower beat when the two beats are back to back.
- R6: An upper beat presented in the same cycle as any half-width request is not started. The staged lower half is kept, and a later lone upper beat completes the permute using it.
- R7: An upper beat with no staged lower half produces no result.
- R8: While reset is high and on the first cycle after it, all valid flags and the tag are low and no lower half is staged.
- R9: A new lower beat replaces one already staged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s0_vld | input | 1 | Half-width request on lower half |
| s0_idx | input | 256 | Index bytes, lower half request |
| s0_ta | input | 256 | Table A, lower half request |
| s0_tb | input | 256 | Table B, lower half request |
| s1_vld | input | 1 | Half-width request on upper half |
| s1_idx | input | 256 | Index bytes, upper half request |
| s1_ta | input | 256 | Table A, upper half request |
| s1_tb | input | 256 | Table B, upper half request |
| w_vld | input | 1 | Full-width beat present |
| w_upper | input | 1 | 0 = lower beat, 1 = upper beat |
| w_idx | input | 256 | Index bytes of the current beat |
| w_ta | input | 256 | Table A half of the current beat |
| w_tb | input | 256 | Table B half of the current beat |
| out_vld0 | output | 1 | Lower result half valid |
| out_vld1 | output | 1 | Upper result half valid |
| out_wide | output | 1 | Result comes from a full-mode permute |
| out_data | output | 512 | Result bytes, half 0 in bits 255:0 |

## Verification
A half-width result is due one edge after its request. A full-width result is due one edge after its accepted upper beat, which is two edges after a back-to-back lower beat. A blocked upper beat yields nothing on its edge. The bench changes inputs on the falling edge and reads outputs on the next falling edge, so every expected value falls on exactly one edge. Before each check, the bench works out whether the unit was free or blocked in that cycle. Expected bytes come from a behavioural index model applied to the same random tables.

// File: rtl/perm_pkg.sv
package perm_pkg;
  typedef enum logic {
    XB_SPLIT = 1'b0,
    XB_FULL  = 1'b1
  } xb_mode_e;
endpackage

// File: rtl/perm_stage.sv
module perm_stage #(
  parameter int W = 256
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         clear,
  input  logic [W-1:0] d_idx,
  input  logic [W-1:0] d_ta,
  input  logic [W-1:0] d_tb,
  output logic         q_vld,
  output logic [W-1:0] q_idx,
  output logic [W-1:0] q_ta,
  output logic [W-1:0] q_tb
);
  always_ff @(posedge clk) begin
    if (rst) q_vld <= 1'b0;
    else if (load) q_vld <= 1'b1;
    else if (clear) q_vld <= 1'b0;
  end

  // data without reset so it maps to plain fabric registers
  always_ff @(posedge clk) begin
    if (load) begin
      q_idx <= d_idx;
      q_ta  <= d_ta;
      q_tb  <= d_tb;
    end
  end
endmodule

// File: rtl/perm_xbar.sv
module perm_xbar
  import perm_pkg::*;
#(
  parameter int HALF_BYTES = 32
) (
  input  xb_mode_e                    mode,
  input  logic [2*HALF_BYTES*8-1:0]   idx,
  input  logic [4*HALF_BYTES*8-1:0]   src,
  output logic [2*HALF_BYTES*8-1:0]   dout
);
  localparam int FULL_BYTES = 2 * HALF_BYTES;
  localparam int SRC_BYTES  = 4 * HALF_BYTES;
  localparam int IDX_W      = $clog2(SRC_BYTES);

  logic [7:0] src_b [SRC_BYTES];

  for (genvar i = 0; i < SRC_BYTES; i++) begin : g_src
    assign src_b[i] = src[i*8 +: 8];
  end

  for (genvar j = 0; j < FULL_BYTES; j++) begin : g_out
    localparam logic HSIDE = (j >= HALF_BYTES);
    logic [IDX_W-1:0] sel;
    always_comb begin
      if (mode == XB_FULL) sel = idx[j*8 +: IDX_W];
      else                 sel = {HSIDE, idx[j*8 +: IDX_W-1]};
    end
    assign dout[j*8 +: 8] = src_b[sel];
  end

  if (IDX_W < 8) begin : g_drop
    logic [FULL_BYTES*(8-IDX_W)-1:0] idx_top;
    for (genvar j = 0; j < FULL_BYTES; j++) begin : g_top
      assign idx_top[j*(8-IDX_W) +: (8-IDX_W)] = idx[j*8+IDX_W +: (8-IDX_W)];
    end
    logic unused_idx_top;
    assign unused_idx_top = ^idx_top;
  end
endmodule

// File: rtl/perm_oreg.sv
module perm_oreg #(
  parameter int W = 256
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic         q_vld,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q_vld <= 1'b0;
    else     q_vld <= en;
  end

  always_ff @(posedge clk) begin
    if (en) q <= d;
  end
endmodule

// File: rtl/perm512_split.sv
module perm512_split
  import perm_pkg::*;
#(
  parameter int HALF_BYTES = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      s0_vld,
  input  logic [HALF_BYTES*8-1:0]   s0_idx,
  input  logic [HALF_BYTES*8-1:0]   s0_ta,
  input  logic [HALF_BYTES*8-1:0]   s0_tb,
  input  logic                      s1_vld,
  input  logic [HALF_BYTES*8-1:0]   s1_idx,
  input  logic [HALF_BYTES*8-1:0]   s1_ta,
  input  logic [HALF_BYTES*8-1:0]   s1_tb,
  input  logic                      w_vld,
  input  logic                      w_upper,
  input  logic [HALF_BYTES*8-1:0]   w_idx,
  input  logic [HALF_BYTES*8-1:0]   w_ta,
  input  logic [HALF_BYTES*8-1:0]   w_tb,
  output logic                      out_vld0,
  output logic                      out_vld1,
  output logic                      out_wide,
  output logic [2*HALF_BYTES*8-1:0] out_data
);
  localparam int HW = HALF_BYTES * 8;
  localparam int FW = 2 * HW;
  localparam int SW = 4 * HW;

  logic          narrow_any;
  logic          wide_go;
  logic          h_vld;
  logic [HW-1:0] h_idx, h_ta, h_tb;
  logic [1:0]    s_vld;
  logic [1:0]    o_vld;
  xb_mode_e      mode;
  logic [FW-1:0] xb_idx;
  logic [SW-1:0] xb_src;
  logic [FW-1:0] xb_out;

  assign s_vld      = {s1_vld, s0_vld};
  assign narrow_any = |s_vld;
  // any half-width request owns the crossbar this cycle
  assign wide_go    = w_vld & w_upper & h_vld & ~narrow_any;
  assign mode       = wide_go ? XB_FULL : XB_SPLIT;

  perm_stage #(.W(HW)) u_stage (
    .clk   (clk),
    .rst   (rst),
    .load  (w_vld & ~w_upper),
    .clear (wide_go),
    .d_idx (w_idx),
    .d_ta  (w_ta),
    .d_tb  (w_tb),
    .q_vld (h_vld),
    .q_idx (h_idx),
    .q_ta  (h_ta),
    .q_tb  (h_tb)
  );

  // pool layout: full = {B_hi,B_lo,A_hi,A_lo}; split = {B1,A1,B0,A0}
  always_comb begin
    if (mode == XB_FULL) begin
      xb_idx = {w_idx, h_idx};
      xb_src = {w_tb, h_tb, w_ta, h_ta};
    end else begin
      xb_idx = {s1_idx, s0_idx};
      xb_src = {s1_tb, s1_ta, s0_tb, s0_ta};
    end
  end

  perm_xbar #(.HALF_BYTES(HALF_BYTES)) u_xbar (
    .mode (mode),
    .idx  (xb_idx),
    .src  (xb_src),
    .dout (xb_out)
  );

  for (genvar h = 0; h < 2; h++) begin : g_half
    perm_oreg #(.W(HW)) u_oreg (
      .clk   (clk),
      .rst   (rst),
      .en    (wide_go | s_vld[h]),
      .d     (xb_out[h*HW +: HW]),
      .q_vld (o_vld[h]),
      .q     (out_data[h*HW +: HW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_wide <= 1'b0;
    else     out_wide <= wide_go;
  end

  assign out_vld0 = o_vld[0];
  assign out_vld1 = o_vld[1];
endmodule

// File: rtl/perm512_split_chk.sv
module perm512_split_chk (
  input logic clk,
  input logic rst,
  input logic s0_vld,
  input logic s1_vld,
  input logic w_vld,
  input logic w_upper,
  input logic out_vld0,
  input logic out_vld1,
  input logic out_wide
);
  // R8
  rst_quiet_chk: assert property (@(posedge clk)
    rst |=> (!out_vld0 && !out_vld1 && !out_wide));

  // R4
  narrow_lat_chk: assert property (@(posedge clk) disable iff (rst)
    s0_vld |=> (out_vld0 && !out_wide));

  // R3
  half_indep_chk: assert property (@(posedge clk) disable iff (rst)
    (!s1_vld && !(w_vld && w_upper)) |=> !out_vld1);

  // R5
  wide_both_chk: assert property (@(posedge clk) disable iff (rst)
    out_wide |-> (out_vld0 && out_vld1));

  // R6
  wide_block_chk: assert property (@(posedge clk) disable iff (rst)
    (w_vld && w_upper && (s0_vld || s1_vld)) |=> !out_wide);

  // R7
  wide_src_chk: assert property (@(posedge clk) disable iff (rst)
    (!w_vld || !w_upper) |=> !out_wide);
endmodule

bind perm512_split perm512_split_chk u_chk (.*);

// File: tb/perm512_split_tb.sv
module perm512_split_tb;
  localparam int CLK_P = 10;
  localparam int HB    = 32;
  localparam int HW    = HB * 8;
  localparam int FW    = 2 * HW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          s0_vld = 1'b0, s1_vld = 1'b0, w_vld = 1'b0, w_upper = 1'b0;
  logic [HW-1:0] s0_idx = '0, s0_ta = '0, s0_tb = '0;
  logic [HW-1:0] s1_idx = '0, s1_ta = '0, s1_tb = '0;
  logic [HW-1:0] w_idx = '0, w_ta = '0, w_tb = '0;
  logic          out_vld0, out_vld1, out_wide;
  logic [FW-1:0] out_data;

  int nchk = 0;
  int nerr = 0;

  always #(CLK_P/2) clk = ~clk;

  perm512_split #(.HALF_BYTES(HB)) u_dut (
    .clk(clk), .rst(rst),
    .s0_vld(s0_vld), .s0_idx(s0_idx), .s0_ta(s0_ta), .s0_tb(s0_tb),
    .s1_vld(s1_vld), .s1_idx(s1_idx), .s1_ta(s1_ta), .s1_tb(s1_tb),
    .w_vld(w_vld), .w_upper(w_upper), .w_idx(w_idx), .w_ta(w_ta), .w_tb(w_tb),
    .out_vld0(out_vld0), .out_vld1(out_vld1), .out_wide(out_wide),
    .out_data(out_data)
  );

  function automatic logic [HW-1:0] rnd();
    logic [HW-1:0] r;
    for (int i = 0; i < HW/32; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  // full-mode model: 7-bit index into {B,A}, top bit ignored
  function automatic logic [FW-1:0] mdl_full(input logic [FW-1:0] ix,
                                             input logic [FW-1:0] a,
                                             input logic [FW-1:0] b);
    logic [FW-1:0] r;
    for (int j = 0; j < 2*HB; j++) begin
      int k;
      k = int'(ix[j*8 +: 7]);
      if (k < 2*HB) r[j*8 +: 8] = a[k*8 +: 8];
      else          r[j*8 +: 8] = b[(k-2*HB)*8 +: 8];
    end
    return r;
  endfunction

  // half model: 6-bit index into {B,A} of one half, top two bits ignored
  function automatic logic [HW-1:0] mdl_half(input logic [HW-1:0] ix,
                                             input logic [HW-1:0] a,
                                             input logic [HW-1:0] b);
    logic [HW-1:0] r;
    for (int j = 0; j < HB; j++) begin
      int k;
      k = int'(ix[j*8 +: 6]);
      if (k < HB) r[j*8 +: 8] = a[k*8 +: 8];
      else        r[j*8 +: 8] = b[(k-HB)*8 +: 8];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    s0_vld = 1'b0; s1_vld = 1'b0; w_vld = 1'b0; w_upper = 1'b0;
  endtask

  task automatic put_beat(input logic up, input logic [HW-1:0] ix,
                          input logic [HW-1:0] a, input logic [HW-1:0] b);
    w_vld = 1'b1; w_upper = up; w_idx = ix; w_ta = a; w_tb = b;
  endtask

  task automatic t_reset();
    idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 vld/tag in reset", FW'({out_vld0, out_vld1, out_wide}), '0);
    rst = 1'b0;
    put_beat(1'b1, rnd(), rnd(), rnd());
    @(negedge clk);
    idle();
    chk("R8 R7 upper after reset", FW'({out_vld0, out_vld1, out_wide}), '0);
  endtask

  task automatic t_full(input int n);
    for (int it = 0; it < n; it++) begin
      logic [HW-1:0] li, la, lb, ui, ua, ub;
      li = rnd(); la = rnd(); lb = rnd(); ui = rnd(); ua = rnd(); ub = rnd();
      put_beat(1'b0, li, la, lb);
      @(negedge clk);
      chk("R5 nothing after lower", FW'({out_vld0, out_vld1, out_wide}), '0);
      put_beat(1'b1, ui, ua, ub);
      @(negedge clk);
      idle();
      chk("R5 full flags", FW'({out_vld0, out_vld1, out_wide}), FW'(3'b111));
      chk("R1 full data", out_data, mdl_full({ui, li}, {ua, la}, {ub, lb}));
    end
  endtask

  task automatic t_split(input int n);
    for (int it = 0; it < n; it++) begin
      logic [HW-1:0] i0, a0, b0, i1, a1, b1;
      i0 = rnd(); a0 = rnd(); b0 = rnd(); i1 = rnd(); a1 = rnd(); b1 = rnd();
      s0_vld = 1'b1; s0_idx = i0; s0_ta = a0; s0_tb = b0;
      s1_vld = 1'b1; s1_idx = i1; s1_ta = a1; s1_tb = b1;
      @(negedge clk);
      idle();
      chk("R4 split flags", FW'({out_vld0, out_vld1, out_wide}), FW'(3'b110));
      chk("R2 split data", out_data, {mdl_half(i1, a1, b1), mdl_half(i0, a0, b0)});
    end
  endtask

  task automatic t_single();
    logic [HW-1:0] i1, a1, b1;
    i1 = rnd(); a1 = rnd(); b1 = rnd();
    s0_idx = rnd(); s0_ta = rnd(); s0_tb = rnd();
    s1_vld = 1'b1; s1_idx = i1; s1_ta = a1; s1_tb = b1;
    @(negedge clk);
    idle();
    chk("R3 single upper flags", FW'({out_vld0, out_vld1, out_wide}), FW'(3'b010));
    chk("R3 single upper data", FW'(out_data[FW-1:HW]), FW'(mdl_half(i1, a1, b1)));
  endtask

  task automatic t_block();
    logic [HW-1:0] li, la, lb, ui, ua, ub, i0, a0, b0;
    li = rnd(); la = rnd(); lb = rnd(); ui = rnd(); ua = rnd(); ub = rnd();
    i0 = rnd(); a0 = rnd(); b0 = rnd();
    put_beat(1'b0, li, la, lb);
    @(negedge clk);
    put_beat(1'b1, ui, ua, ub);
    s0_vld = 1'b1; s0_idx = i0; s0_ta = a0; s0_tb = b0;
    @(negedge clk);
    s0_vld = 1'b0;
    chk("R6 blocked flags", FW'({out_vld0, out_vld1, out_wide}), FW'(3'b100));
    chk("R6 narrow wins data", FW'(out_data[HW-1:0]), FW'(mdl_half(i0, a0, b0)));
    @(negedge clk);
    idle();
    chk("R6 retry flags", FW'({out_vld0, out_vld1, out_wide}), FW'(3'b111));
    chk("R6 retry uses kept lower", out_data, mdl_full({ui, li}, {ua, la}, {ub, lb}));
  endtask

  task automatic t_orphan();
    put_beat(1'b1, rnd(), rnd(), rnd());
    @(negedge clk);
    idle();
    chk("R7 orphan upper", FW'({out_vld0, out_vld1, out_wide}), '0);
  endtask

  task automatic t_replace();
    logic [HW-1:0] li, la, lb, ui, ua, ub;
    li = rnd(); la = rnd(); lb = rnd(); ui = rnd(); ua = rnd(); ub = rnd();
    put_beat(1'b0, rnd(), rnd(), rnd());
    @(negedge clk);
    put_beat(1'b0, li, la, lb);
    @(negedge clk);
    put_beat(1'b1, ui, ua, ub);
    @(negedge clk);
    idle();
    chk("R9 replaced lower flags", FW'({out_vld0, out_vld1, out_wide}), FW'(3'b111));
    chk("R9 replaced lower data", out_data, mdl_full({ui, li}, {ua, la}, {ub, lb}));
  endtask

  initial begin
    #(CLK_P * 50000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nerr);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_full(20);
    t_split(20);
    t_single();
    t_block();
    t_orphan();
    t_replace();
    t_split(5);
    t_full(5);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nerr);
    $finish;
  end
endmodule